// File: doc/BRIEF.md
# Framed SPI Register-Read Port

This block is the slave side of a serial register-read interface. Its traffic is cut into fixed 16-bit words while chip select is held low. Each word the host clocks in may carry a read command. The data for that command comes back in the word that follows. The follow-on word may sit in the same select window or in a later one. The serial lines and the data-ready strobe are sampled in the system clock domain. Each SCLK edge is counted, and the count is judged at the moment chip select returns high.

Windows whose edge count is not a whole number of words are treated as framing faults, and there are two kinds. If the stray edges follow at least one complete word, the port enters a recoverable error state. The host clears it with a single window of exactly seventeen edges. If the window ends before its first word is complete, the port locks until the hard reset input is pulsed. Separately, the port counts reads between data-ready pulses. It raises a datapath-overrun bit once the count passes a budget that scales with the decimation setting.

Top module: `spi_seg_port`

## Requirements
- R1: Bits are taken on SCLK rising edges and driven on falling edges, MSB first, in SPI mode 3. A word ends on its 16th rising edge. A read command has bit 15 = 0 and the address in bits 14:8. Its data is shifted out in the next word, even if that word falls in a later select window.
- R2: Address 0x01 returns the identification constant ID_VAL. Address 0x02 returns the diagnostic word, with the overrun flag in bit 0. Addresses 0x10+i return sensor word i. Any other address returns 0, and a word with bit 15 = 1 yields a zero response.
- R3: A window that ends with 17 or more edges and a count that is not a multiple of 16 sets `ovr_err`. While `ovr_err` is set, read commands are ignored and the responses read as 0.
- R4: While `ovr_err` is set, a window of exactly 17 edges clears it, and the next read of address 0x01 returns ID_VAL. A window of any other length leaves the error in place.
- R5: A window that ends with 1 to 15 edges sets `locked`. No SPI activity clears it, including 17-edge windows, and reads return 0. Only `rst_n` low clears it.
- R6: A window whose edge count is a multiple of 16, including zero, sets no fault.
- R7: Between data-ready pulses the port allows 12*(dec_rate+1) reads. The read after that sets the overrun flag, and reads up to the limit leave it clear. A diagnostic read returns the flag as it stood before that read.
- R8: A pulse on `drdy` restarts the read count.
- R9: A read of the diagnostic word clears the overrun flag, unless that same read sets it again.
- R10: After reset, `miso` is 0 and `ovr_err`, `locked` and the overrun flag are all clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| drdy | input | 1 | Data-ready strobe, one clk pulse |
| dec_rate | input | DEC_W | Decimation setting (factor = value + 1) |
| sens_data | input | NDATA*16 | Sensor words, word i at bits 16i+15:16i |
| ovr_err | output | 1 | Recoverable framing error (extra clocks) |
| locked | output | 1 | Lock-up after a short window |

## Verification
The windows used hold exact multiples of 16 edges (0, 16, 32, 48 and long bursts), 17 and 20 edges after whole words, 33 edges, and 5 edges. Together these separate a clean window, the recoverable fault, the one recovery length, a harmless mismatch inside the error state, and the short window that locks. The read budget is tested at exactly the limit and one past it, for decimation settings 0 and 2. A further pattern of two bursts of ten reads split by a data-ready pulse shows that the count restarts. Diagnostic reads placed before and after the clearing read show the flag's read-then-clear behaviour and its priority.

// File: rtl/spi_seg_port.sv
module spi_seg_port #(
  parameter logic [15:0] ID_VAL    = 16'h3E91,
  parameter int          NDATA     = 4,
  parameter int          DEC_W     = 4,
  parameter int          RD_BASE   = 12,
  parameter logic [6:0]  ADDR_ID   = 7'h01,
  parameter logic [6:0]  ADDR_DIAG = 7'h02,
  parameter logic [6:0]  DATA_BASE = 7'h10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               cs_n,
  input  logic               mosi,
  output logic               miso,
  input  logic               drdy,
  input  logic [DEC_W-1:0]   dec_rate,
  input  logic [NDATA*16-1:0] sens_data,
  output logic               ovr_err,
  output logic               locked
);
  localparam int LIM_W = $clog2(RD_BASE * (1 << DEC_W) + 1) + 1;

  logic sclk_m, sclk_s, sclk_d, cs_m, cs_s, cs_d, mosi_m, mosi_s;
  logic [3:0]  bitcnt;
  logic [4:0]  edges;
  logic [15:0] rx, tx, shreg, rd_data;
  logic [LIM_W-1:0] rd_cnt;
  logic ovf;

  wire active    = ~cs_s;
  wire rise      = sclk_s & ~sclk_d & active;
  wire fall      = ~sclk_s & sclk_d & active;
  wire cs_rise   = cs_s & ~cs_d;
  wire word_done = rise & (bitcnt == 4'd15);
  wire [15:0] cmd = {rx[14:0], mosi_s};
  wire is_read   = word_done & ~cmd[15] & ~ovr_err & ~locked;
  wire [LIM_W-1:0] limit = LIM_W'(RD_BASE) * (LIM_W'(dec_rate) + LIM_W'(1));
  wire ovf_set   = is_read & (rd_cnt >= limit);
  wire diag_clr  = is_read & (cmd[14:8] == ADDR_DIAG);

  assign miso = shreg[15];

  always_comb begin
    rd_data = '0;
    if (cmd[14:8] == ADDR_ID)   rd_data = ID_VAL;
    if (cmd[14:8] == ADDR_DIAG) rd_data = {15'd0, ovf};
    for (int i = 0; i < NDATA; i++)
      if (cmd[14:8] == 7'(DATA_BASE + 7'(i))) rd_data = sens_data[i*16 +: 16];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sclk_m, sclk_s, sclk_d} <= 3'b111;
      {cs_m, cs_s, cs_d}       <= 3'b111;
      {mosi_m, mosi_s}         <= 2'b00;
    end else begin
      {sclk_m, sclk_s, sclk_d} <= {sclk, sclk_m, sclk_s};
      {cs_m, cs_s, cs_d}       <= {cs_n, cs_m, cs_s};
      {mosi_m, mosi_s}         <= {mosi, mosi_m};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt <= '0; edges <= '0; rx <= '0; tx <= '0; shreg <= '0;
      ovr_err <= 1'b0; locked <= 1'b0;
    end else begin
      if (!active) begin
        bitcnt <= '0;
        edges  <= '0;
      end else if (rise) begin
        bitcnt <= bitcnt + 4'd1;
        edges  <= (edges == 5'd31) ? edges : edges + 5'd1;
        rx     <= cmd;
      end
      if (word_done) tx <= is_read ? rd_data : 16'd0;
      if (fall) shreg <= (bitcnt == 4'd0) ? ((ovr_err | locked) ? 16'd0 : tx) : {shreg[14:0], 1'b0};
      if (cs_rise && !locked) begin
        if (bitcnt != 4'd0 && edges < 5'd16) begin
          locked  <= 1'b1;
          ovr_err <= 1'b0;
        end else if (ovr_err) begin
          if (edges == 5'd17) ovr_err <= 1'b0;
        end else if (bitcnt != 4'd0) begin
          ovr_err <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
      ovf    <= 1'b0;
    end else begin
      if (drdy)                         rd_cnt <= is_read ? LIM_W'(1) : '0;
      else if (is_read && rd_cnt < limit) rd_cnt <= rd_cnt + LIM_W'(1);
      ovf <= ovf_set | (ovf & ~diag_clr);
    end
  end
endmodule

module spi_seg_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s,
  input logic       cs_d,
  input logic       cs_rise,
  input logic       word_done,
  input logic [3:0] bitcnt,
  input logic       ovr_err,
  input logic       locked,
  input logic       ovf
);
  AST_IDLE_NO_BITS: assert property (@(posedge clk) disable iff (!rst_n) (cs_s && cs_d) |-> (bitcnt == 4'd0)); // R1
  AST_ERR_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovr_err) |-> $past(cs_rise)); // R3
  AST_RECOVER_AT_WINDOW_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(ovr_err) |-> $past(cs_rise)); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) locked |=> locked); // R5
  AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(locked && ovr_err)); // R5
  AST_OVF_SET_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf) |-> $past(word_done)); // R7
  AST_OVF_CLR_ON_WORD: assert property (@(posedge clk) disable iff (!rst_n) $fell(ovf) |-> $past(word_done)); // R9
endmodule

bind spi_seg_port spi_seg_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_d(cs_d), .cs_rise(cs_rise),
  .word_done(word_done), .bitcnt(bitcnt), .ovr_err(ovr_err), .locked(locked), .ovf(ovf)
);

// File: tb/spi_seg_port_test.sv
module spi_seg_port_test;
  localparam int CLK_P = 10;
  localparam int HALF  = 5;
  localparam logic [15:0] ID = 16'h3E91;
  localparam logic [15:0] WR = 16'h8000;

  logic clk = 0, rst_n = 0, sclk = 1, cs_n = 1, mosi = 0, drdy = 0;
  logic [3:0]  dec_rate = 0;
  logic [63:0] sens_data = {16'hD004, 16'hC003, 16'hB002, 16'hA001};
  logic miso, ovr_err, locked;
  logic [15:0] cmd_q [0:63];
  logic [15:0] rsp_q [0:63];
  int checks = 0, errors = 0;
  bit done = 0;

  spi_seg_port uut (.clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso),
    .drdy(drdy), .dec_rate(dec_rate), .sens_data(sens_data), .ovr_err(ovr_err), .locked(locked));

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] rd(input logic [6:0] a);
    return {1'b0, a, 8'h00};
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic fill(input logic [15:0] v);
    for (int i = 0; i < 64; i++) begin cmd_q[i] = v; rsp_q[i] = 'x; end
  endtask

  task automatic window(input int n);
    cs_n = 0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 0;
      mosi = cmd_q[i/16][15 - (i%16)];
      repeat (HALF) @(negedge clk);
      rsp_q[i/16][15 - (i%16)] = miso;
      sclk = 1;
      repeat (HALF) @(negedge clk);
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1;
    repeat (10) @(negedge clk);
  endtask

  task automatic pulse_drdy();
    drdy = 1; @(negedge clk); drdy = 0; repeat (3) @(negedge clk);
  endtask

  task automatic hard_reset();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R10 miso", 16'(miso), 16'd0);
    chk("R10 ovr_err", 16'(ovr_err), 16'd0);
    chk("R10 locked", 16'(locked), 16'd0);
    fill(WR); cmd_q[0] = rd(7'h02);
    window(32);
    chk("R10 diag after reset", rsp_q[1], 16'd0);
  endtask

  task automatic t_basic();
    pulse_drdy();
    fill(WR); cmd_q[0] = rd(7'h01); cmd_q[1] = rd(7'h10);
    window(48);
    chk("R1 id in next word", rsp_q[1], ID);
    chk("R2 data0", rsp_q[2], 16'hA001);
    fill(WR); cmd_q[0] = rd(7'h13);
    window(16);
    chk("R2 write gives zero", rsp_q[0], 16'd0);
    fill(WR); cmd_q[0] = rd(7'h7F);
    window(16);
    chk("R1 response across windows", rsp_q[0], 16'hD004);
    fill(WR);
    window(16);
    chk("R2 unknown address", rsp_q[0], 16'd0);
    window(0);
    chk("R6 empty window", {14'd0, ovr_err, locked}, 16'd0);
    window(64);
    chk("R6 four words", {14'd0, ovr_err, locked}, 16'd0);
  endtask

  task automatic t_overrun();
    pulse_drdy();
    fill(WR);
    window(20);
    chk("R3 20 edges sets error", 16'(ovr_err), 16'd1);
    fill(WR); cmd_q[0] = rd(7'h01);
    window(32);
    chk("R3 read ignored in error", rsp_q[1], 16'd0);
    fill(WR);
    window(33);
    chk("R4 33 edges keeps error", 16'(ovr_err), 16'd1);
    window(16);
    chk("R4 16 edges keeps error", 16'(ovr_err), 16'd1);
    window(17);
    chk("R4 17 edges clears error", 16'(ovr_err), 16'd0);
    chk("R4 no lock after recovery", 16'(locked), 16'd0);
    fill(WR); cmd_q[0] = rd(7'h01);
    window(32);
    chk("R4 id valid after recovery", rsp_q[1], ID);
  endtask

  task automatic t_underrun();
    fill(WR);
    window(5);
    chk("R5 short window locks", 16'(locked), 16'd1);
    window(17);
    chk("R5 17 edges keep lock", 16'(locked), 16'd1);
    fill(WR); cmd_q[0] = rd(7'h01);
    window(32);
    chk("R5 read ignored while locked", rsp_q[1], 16'd0);
    chk("R5 still locked", 16'(locked), 16'd1);
    hard_reset();
    chk("R5 reset clears lock", 16'(locked), 16'd0);
    fill(WR); cmd_q[0] = rd(7'h01);
    window(32);
    chk("R5 id after reset", rsp_q[1], ID);
  endtask

  task automatic t_rate(input logic [3:0] d);
    int lim = 12 * (int'(d) + 1);
    int w = 0;
    dec_rate = d;
    pulse_drdy();
    while (w < lim) begin
      int n = (lim - w > 40) ? 40 : lim - w;
      fill(WR);
      for (int i = 0; i < n; i++) cmd_q[i] = rd(7'h10);
      if (w + n == lim) cmd_q[n-1] = rd(7'h02);
      window((n + 1) * 16);
      if (w + n == lim) chk($sformatf("R7 diag at limit dec=%0d", d), rsp_q[n], 16'd0);
      w += n;
    end
    fill(WR); cmd_q[0] = rd(7'h10); cmd_q[1] = rd(7'h02);
    window(48);
    chk($sformatf("R7 read past limit sets flag dec=%0d", d), rsp_q[2], 16'd1);
    pulse_drdy();
    fill(WR); cmd_q[0] = rd(7'h02); cmd_q[1] = rd(7'h02);
    window(48);
    chk("R9 diag read returns set flag", rsp_q[1], 16'd1);
    chk("R9 second diag read sees cleared", rsp_q[2], 16'd0);
    dec_rate = 0;
  endtask

  task automatic t_restart();
    pulse_drdy();
    fill(WR);
    for (int i = 0; i < 10; i++) cmd_q[i] = rd(7'h11);
    window(176);
    chk("R8 data1 response", rsp_q[1], 16'hB002);
    pulse_drdy();
    fill(WR);
    for (int i = 0; i < 10; i++) cmd_q[i] = rd(7'h11);
    cmd_q[10] = rd(7'h02);
    window(192);
    cmd_q[0] = WR;
    fill(WR); cmd_q[0] = rd(7'h02);
    window(32);
    chk("R8 count restarted by drdy", rsp_q[1], 16'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_overrun();
    t_underrun();
    t_rate(4'd0);
    t_rate(4'd2);
    t_restart();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule